// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the slower memory below it. Every store that the cache passes down arrives as a block-addressed request with block-wide data and a per-byte enable mask. An accepted request is finished as far as the writer is concerned. It is parked in one of a small number of block-sized entries, and those entries are written out to memory in the background through a valid/ready write port.

When a store targets a block that already sits in a waiting entry, its enabled bytes are folded into that entry: they replace the stored bytes and are added to the entry's byte mask. No second slot is taken. The entry at the front of the queue is the one on offer to memory. It is frozen, so a store to its block opens a new entry behind it. When every entry is taken and no fold is possible, the block raises a stall. The writer must then keep its request steady until a slot frees. A slot that frees in the same cycle is handed to the waiting store at once.

Top module: `merge_write_buffer`

## Requirements
- R1: After reset, no entry is occupied, `mem_valid` is low and `wr_stall` is low.
- R2: A write presented while a slot is free is taken in that cycle with `wr_stall` low. Its entry later appears on the memory port with the same block address, with data equal to the write data in enabled bytes and zero in all other bytes, and with `mem_be` equal to the write's byte enables (bit k covers data bits 8k+7..8k).
- R3: A write to a block held in an occupied entry that is not at the front of the queue is folded into that entry. Its enabled bytes overwrite the stored bytes, its enables are OR-ed into the entry mask, no entry is added, and `wr_stall` stays low.
- R4: Entries leave in allocation order, one per cycle in which `mem_valid` and `mem_ready` are both high. While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_data` and `mem_be` hold steady.
- R5: With all 4 entries occupied, no fold possible and no entry leaving, a presented write sees `wr_stall` high and is not taken.
- R6: With all entries occupied, a write that cannot fold is taken without a stall in a cycle in which the front entry is accepted by memory.
- R7: The front entry never takes a fold: a write to its block occupies a new entry, and the front entry's mask is drained unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | Store request present |
| wr_addr | input | ADDR_W | Block address of the store |
| wr_data | input | 8*BLK_BYTES | Block-wide store data |
| wr_be | input | BLK_BYTES | Byte enables of the store |
| wr_stall | output | 1 | Store cannot be taken this cycle; hold it |
| mem_valid | output | 1 | Front entry offered to memory |
| mem_addr | output | ADDR_W | Block address of the front entry |
| mem_data | output | 8*BLK_BYTES | Data of the front entry |
| mem_be | output | BLK_BYTES | Byte mask of the front entry |
| mem_ready | input | 1 | Memory accepts the offered entry |

## Verification
On every cycle the assertions watch the memory-side handshake: offered address, data and mask stay frozen while memory holds off, and each accepted write frees exactly one slot when no store arrives. They also check that a fold or a freeing slot never coexists with a stall, that a stall only occurs with a request and a blocked front entry, and that at most one entry can ever be a fold target. The byte-level content of folded entries, the oldest-first drain order, the fresh slot behind a frozen front entry and the zeroing of unwritten bytes depend on the history of stores. Only the bench's scenarios, compared against its reference queue, can show them.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_ALLOC = 2'd1,
    OP_MERGE = 2'd2
  } wbuf_op_e;

endpackage

// File: rtl/wbuf_rst_sync.sv
module wbuf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl #(
  parameter int N     = 4,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             hit,
  input  logic             mem_ready,
  output logic [N-1:0]     occ,
  output logic [N-1:0]     mergeable,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic             mem_valid,
  output logic             alloc,
  output logic             wr_stall
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(N - 1);

  logic [N-1:0]     occ_q, occ_d;
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic             full, drain;
  logic [N-1:0]     head_1h;

  always_comb begin
    full      = &occ_q;
    mem_valid = occ_q[head_q];
    drain     = mem_valid & mem_ready;
    alloc     = wr_valid & ~hit & (~full | drain);
    wr_stall  = wr_valid & ~hit & full & ~drain;

    head_1h   = '0;
    head_1h[head_q] = 1'b1;
    mergeable = occ_q & ~head_1h;

    occ_d = occ_q;
    if (drain) occ_d[head_q] = 1'b0;
    if (alloc) occ_d[tail_q] = 1'b1;

    head_d = head_q;
    if (drain) head_d = (head_q == LAST) ? '0 : head_q + 1'b1;
    tail_d = tail_q;
    if (alloc) tail_d = (tail_q == LAST) ? '0 : tail_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
    end else begin
      occ_q  <= occ_d;
      if (drain) head_q <= head_d;
      if (alloc) tail_q <= tail_d;
    end
  end

  assign occ  = occ_q;
  assign head = head_q;
  assign tail = tail_q;

endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int N      = 4,
  parameter int ADDR_W = 28,
  parameter int PTR_W  = 2
) (
  input  logic [N-1:0]             mergeable,
  input  logic [N-1:0][ADDR_W-1:0] entry_addr,
  input  logic [ADDR_W-1:0]        wr_addr,
  output logic [N-1:0]             cand,
  output logic                     hit,
  output logic [PTR_W-1:0]         hit_idx
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign cand[i] = mergeable[i] && (entry_addr[i] == wr_addr);
  end

  always_comb begin
    hit     = |cand;
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) hit_idx = PTR_W'(i);
    end
  end

endmodule

// File: rtl/wbuf_store.sv
module wbuf_store
  import wbuf_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 28,
  parameter int BYTES  = 8,
  parameter int PTR_W  = 2
) (
  input  logic                     clk,
  input  wbuf_op_e                 op,
  input  logic [PTR_W-1:0]         op_idx,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [BYTES-1:0][7:0]    wr_data,
  input  logic [BYTES-1:0]         wr_be,
  input  logic [PTR_W-1:0]         rd_idx,
  output logic [N-1:0][ADDR_W-1:0] entry_addr,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic [BYTES-1:0][7:0]    rd_data,
  output logic [BYTES-1:0]         rd_be
);

  logic [N-1:0][BYTES-1:0][7:0] data_q;
  logic [N-1:0][BYTES-1:0]      mask_q;
  logic [N-1:0][ADDR_W-1:0]     addr_q;

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic                  sel, do_alloc, do_merge;
    logic [BYTES-1:0][7:0] data_d;
    logic [BYTES-1:0]      mask_d;

    always_comb begin
      sel      = (op_idx == PTR_W'(i));
      do_alloc = sel && (op == OP_ALLOC);
      do_merge = sel && (op == OP_MERGE);
      data_d   = data_q[i];
      for (int b = 0; b < BYTES; b++) begin
        if (do_alloc)                data_d[b] = wr_be[b] ? wr_data[b] : 8'h00;
        else if (do_merge && wr_be[b]) data_d[b] = wr_data[b];
      end
      mask_d = do_alloc ? wr_be : (mask_q[i] | wr_be);
    end

    always_ff @(posedge clk) begin
      if (do_alloc) addr_q[i] <= wr_addr;
      if (do_alloc || do_merge) begin
        data_q[i] <= data_d;
        mask_q[i] <= mask_d;
      end
    end
  end

  assign entry_addr = addr_q;
  assign rd_addr    = addr_q[rd_idx];
  assign rd_data    = data_q[rd_idx];
  assign rd_be      = mask_q[rd_idx];

endmodule

// File: rtl/merge_write_buffer.sv
module merge_write_buffer
  import wbuf_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int ADDR_W    = 28,
  parameter int BLK_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [8*BLK_BYTES-1:0] wr_data,
  input  logic [BLK_BYTES-1:0]   wr_be,
  output logic                   wr_stall,
  output logic                   mem_valid,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [8*BLK_BYTES-1:0] mem_data,
  output logic [BLK_BYTES-1:0]   mem_be,
  input  logic                   mem_ready
);

  localparam int PTR_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic                             rst_sync_n;
  logic [N_ENTRIES-1:0]             occ, mergeable, cand;
  logic [PTR_W-1:0]                 head, tail, hit_idx, op_idx;
  logic                             hit, alloc;
  logic [N_ENTRIES-1:0][ADDR_W-1:0] entry_addr;
  logic [BLK_BYTES-1:0][7:0]        rd_data;
  wbuf_op_e                         op;

  wbuf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wbuf_ctrl #(.N(N_ENTRIES), .PTR_W(PTR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_valid  (wr_valid),
    .hit       (hit),
    .mem_ready (mem_ready),
    .occ       (occ),
    .mergeable (mergeable),
    .head      (head),
    .tail      (tail),
    .mem_valid (mem_valid),
    .alloc     (alloc),
    .wr_stall  (wr_stall)
  );

  wbuf_match #(.N(N_ENTRIES), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_match (
    .mergeable  (mergeable),
    .entry_addr (entry_addr),
    .wr_addr    (wr_addr),
    .cand       (cand),
    .hit        (hit),
    .hit_idx    (hit_idx)
  );

  always_comb begin
    if (wr_valid && hit) begin
      op     = OP_MERGE;
      op_idx = hit_idx;
    end else if (alloc) begin
      op     = OP_ALLOC;
      op_idx = tail;
    end else begin
      op     = OP_IDLE;
      op_idx = tail;
    end
  end

  wbuf_store #(.N(N_ENTRIES), .ADDR_W(ADDR_W), .BYTES(BLK_BYTES), .PTR_W(PTR_W)) u_store (
    .clk        (clk),
    .op         (op),
    .op_idx     (op_idx),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_be      (wr_be),
    .rd_idx     (head),
    .entry_addr (entry_addr),
    .rd_addr    (mem_addr),
    .rd_data    (rd_data),
    .rd_be      (mem_be)
  );

  assign mem_data = rd_data;

endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker #(
  parameter int N      = 4,
  parameter int ADDR_W = 28,
  parameter int BYTES  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_valid,
  input logic               wr_stall,
  input logic               mem_valid,
  input logic               mem_ready,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [8*BYTES-1:0] mem_data,
  input logic [BYTES-1:0]   mem_be,
  input logic               hit,
  input logic [N-1:0]       cand,
  input logic [N-1:0]       occ
);

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be));

  p_drain_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && !wr_valid |=> $countones(occ) == $countones($past(occ)) - 1);

  p_merge_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && hit |-> !wr_stall);

  p_single_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cand));

  p_stall_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stall |-> wr_valid && mem_valid && !mem_ready);

  p_free_same_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |-> !wr_stall);

endmodule

bind merge_write_buffer wbuf_checker #(
  .N(N_ENTRIES), .ADDR_W(ADDR_W), .BYTES(BLK_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_valid  (wr_valid),
  .wr_stall  (wr_stall),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .mem_be    (mem_be),
  .hit       (hit),
  .cand      (cand),
  .occ       (occ)
);

// File: tb/merge_write_buffer_test.sv
module merge_write_buffer_test;

  localparam int NE = 4;
  localparam int AW = 28;
  localparam int NB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [63:0]   wr_data = '0;
  logic [NB-1:0] wr_be = '0;
  logic          wr_stall, mem_valid, mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_data;
  logic [NB-1:0] mem_be;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference queue, index 0 is the front
  int            mc = 0;
  logic [AW-1:0] ma [NE];
  logic [63:0]   md [NE];
  logic [NB-1:0] mm [NE];
  int            e_hidx;
  bit            e_stall, e_drain;
  logic          o_stall, o_valid;
  logic [NB-1:0] o_be;
  logic [63:0]   o_data;

  always #5 clk = ~clk;

  merge_write_buffer #(.N_ENTRIES(NE), .ADDR_W(AW), .BLK_BYTES(NB)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .wr_stall(wr_stall),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_be(mem_be), .mem_ready(mem_ready)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] apply_bytes(input logic [63:0] old, input logic [63:0] nw, input logic [NB-1:0] be);
    logic [63:0] r = old;
    for (int b = 0; b < NB; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  // one clock: drive at falling edge, compare, advance reference
  task automatic cyc(input logic v, input logic [AW-1:0] a, input logic [63:0] d,
                     input logic [NB-1:0] be, input logic rdy);
    string st;
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d; wr_be = be; mem_ready = rdy;
    #1;
    e_hidx = -1;
    for (int j = 1; j < mc; j++) if (ma[j] == a && e_hidx < 0) e_hidx = j;
    e_drain = (mc > 0) && rdy;
    e_stall = v && (e_hidx < 0) && (mc == NE) && !e_drain;
    if (e_stall) st = "R5";
    else if (v && e_hidx < 0 && mc == NE) st = "R6";
    else if (v && e_hidx >= 0) st = "R3";
    else st = "R2";
    chk(st, "wr_stall", 64'(wr_stall), 64'(e_stall));
    chk("R4", "mem_valid", 64'(mem_valid), 64'(mc > 0));
    if (mc > 0) begin
      chk("R4", "mem_addr", 64'(mem_addr), 64'(ma[0]));
      chk("R2", "mem_data", mem_data, md[0]);
      chk("R2", "mem_be", 64'(mem_be), 64'(mm[0]));
    end
    o_stall = wr_stall; o_valid = mem_valid; o_be = mem_be; o_data = mem_data;
    if (v && e_hidx >= 0) begin
      md[e_hidx] = apply_bytes(md[e_hidx], d, be);
      mm[e_hidx] = mm[e_hidx] | be;
    end
    if (e_drain) begin
      for (int j = 0; j < NE - 1; j++) begin
        ma[j] = ma[j+1]; md[j] = md[j+1]; mm[j] = mm[j+1];
      end
      mc--;
    end
    if (v && !e_stall && e_hidx < 0) begin
      ma[mc] = a; md[mc] = apply_bytes(64'h0, d, be); mm[mc] = be; mc++;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic          hv;
    logic [AW-1:0] ha;
    logic [63:0]   hd;
    logic [NB-1:0] hb;
    logic          rdy;
    void'($urandom(32'd5713));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: idle after reset
    #1;
    chk("R1", "mem_valid", 64'(mem_valid), 64'd0);
    chk("R1", "wr_stall", 64'(wr_stall), 64'd0);

    // R2, R7, R3: front entry frozen, later store folds into second entry
    cyc(1, 28'h005, 64'h1111_2222_3333_4444, 8'h0F, 0);
    chk("R2", "stall on free slot", 64'(o_stall), 64'd0);
    cyc(1, 28'h005, 64'h5555_6666_7777_8888, 8'h30, 0);
    cyc(1, 28'h005, 64'h9999_AAAA_BBBB_CCCC, 8'hC0, 0);
    chk("R3", "stall on fold", 64'(o_stall), 64'd0);
    cyc(0, '0, '0, '0, 0);
    cyc(0, '0, '0, '0, 1);
    chk("R7", "front mask unchanged", 64'(o_be), 64'h0F);
    chk("R2", "unwritten bytes zero", o_data, 64'h0000_0000_3333_4444);
    cyc(0, '0, '0, '0, 1);
    chk("R3", "folded mask", 64'(o_be), 64'hF0);
    chk("R3", "folded data", o_data, 64'h9999_6666_0000_0000);
    cyc(0, '0, '0, '0, 1);
    chk("R3", "no extra entry", 64'(o_valid), 64'd0);

    // R5, R6: fill, stall, then same-cycle free
    for (int k = 0; k < NE; k++) cyc(1, 28'h100 + 28'(k), 64'(k + 1) * 64'h0101_0101_0101_0101, 8'hFF, 0);
    for (int k = 0; k < 3; k++) begin
      cyc(1, 28'h1FF, 64'hDEAD_BEEF_0BAD_F00D, 8'hFF, 0);
      chk("R5", "stall when full", 64'(o_stall), 64'd1);
    end
    cyc(1, 28'h1FF, 64'hDEAD_BEEF_0BAD_F00D, 8'hFF, 1);
    chk("R6", "take on same-cycle free", 64'(o_stall), 64'd0);
    for (int k = 0; k < NE + 1; k++) cyc(0, '0, '0, '0, 1);
    chk("R4", "drained empty", 64'(o_valid), 64'd0);

    // random traffic, stalled requests held
    hv = 0; ha = '0; hd = '0; hb = '0;
    for (int n = 0; n < 4000; n++) begin
      if (!(hv && o_stall)) begin
        hv = ($urandom_range(0, 3) != 0);
        ha = 28'h200 + 28'($urandom_range(0, 5));
        hd = {$urandom, $urandom};
        hb = NB'($urandom);
      end
      rdy = ((n / 150) % 2 == 0) ? ($urandom_range(0, 9) < 8) : ($urandom_range(0, 9) < 2);
      cyc(hv, ha, hd, hb, rdy);
    end
    for (int k = 0; k < NE + 2; k++) cyc(0, '0, '0, '0, 1);
    chk("R4", "final drain", 64'(o_valid), 64'd0);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule